// File: doc/BRIEF.md
# Dual Interval Timer with Write-Busy Status

This block holds two down-counting interval timers and a write-busy indicator for the host side of a sound synthesizer. A prescaler divides the master clock enable into a fast update tick. The tick occurs once every `PRESCALE` enabled clocks, 144 by default. A further divide-by-`SLOW_DIV` stage, 16 by default, makes a slow tick. The fast timer counts on the fast tick and the slow timer counts on the slow tick.

When a counter that is already zero receives an update tick, it reloads from its register and reports an overflow. That overflow latches a status flag, but only when the timer's overflow-enable bit is set. The flags stay set until the host clears them through reset bits in the control byte.

Every register write raises a busy bit in the status byte. The bit stays up for a fixed number of enabled clocks after the last write. The host writes one byte at a time through a two-bit register select. It reads the status byte, which is driven continuously.

Top module: `dual_interval_timer`

## Requirements
- R1: All timing advances only on clocks with `clk_en` high. The fast tick occurs on one enabled clock in every `PRESCALE`. The slow tick occurs on one fast tick in every `SLOW_DIV`. With `clk_en` low, neither timer, the prescaler nor the busy countdown changes.
- R2: The fast timer's reload value is 10 bits wide. Its upper 8 bits come from the register at select 0, and its lower 2 bits are bits 1:0 of the register at select 1; bits 7:2 of that register are ignored. While running, the fast timer overflows once every (reload+1) fast ticks.
- R3: The slow timer's reload value is the whole 8-bit register at select 2. While running, the slow timer overflows once every (reload+1) slow ticks.
- R4: A timer changes only on its own tick, and only while its run bit is set. The run bits are control bit 0 for the fast timer and control bit 1 for the slow timer.
- R5: On an update, a nonzero count decrements by one. A zero count loads the reload value and signals an overflow. Counts reset to zero, so the first tick after a timer is started gives an overflow.
- R6: An overflow sets status bit 0 (fast timer) or status bit 1 (slow timer) only while the matching overflow-enable bit is set: control bit 2 for the fast timer, control bit 3 for the slow timer.
- R7: Status bits 0 and 1 stay set until cleared. A control write with bit 4 set clears status bit 0, and one with bit 5 set clears status bit 1. These two bits act only on that write and are not stored. If an overflow and a clear for the same flag fall on the same clock, the flag ends up set.
- R8: Any write sets status bit 7 on the next clock. The bit stays set for exactly `BUSY_LEN` enabled clocks after the last write, 17 by default, and a further write restarts the window.
- R9: After reset the status byte is zero, all registers and counts are zero and the prescaler phase is zero.
- R10: `wr_sel` selects the register being written: 0 is the fast timer's high byte, 1 its low bits, 2 the slow timer's reload and 3 the control byte. Status bits 6:2 always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Master clock enable; one enabled clock is one timing unit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data |
| status | output | 8 | Bit 7 busy, bit 1 slow-timer flag, bit 0 fast-timer flag |

## Verification
The assertions watch several rules on every cycle. A count stays frozen unless its own tick arrives with its run bit set. An overflow always reloads the count, and a nonzero count steps down by exactly one. A flag never rises without an enabled overflow, and once set it holds until a clear write. A write always raises busy, and busy never rises without a write.

Only the bench scenarios can show the end-to-end periods. For every small reload value and for the largest ones, the bench measures the overflow interval in clocks and compares it with (reload+1) times the tick spacing. The scenarios also measure the exact length of the busy window and its restart, the freeze under a low clock enable, and the selective flag clears.

// File: rtl/dit_pkg.sv
package dit_pkg;

    typedef enum logic [1:0] {
        SEL_FAST_HI = 2'd0,
        SEL_FAST_LO = 2'd1,
        SEL_SLOW    = 2'd2,
        SEL_CTRL    = 2'd3
    } reg_sel_e;

    // stored control bits, packed so that bit 3..0 match the control byte
    typedef struct packed {
        logic ovf_en_slow;
        logic ovf_en_fast;
        logic run_slow;
        logic run_fast;
    } ctrl_t;

    typedef struct packed {
        logic [7:0] fast_hi;
        logic [1:0] fast_lo;
        logic [7:0] slow_rel;
        ctrl_t      ctrl;
        logic       flag_slow;
        logic       flag_fast;
    } regs_t;

    localparam int CLR_FAST_BIT = 4;
    localparam int CLR_SLOW_BIT = 5;

endpackage

// File: rtl/dit_prescaler.sv
module dit_prescaler #(
    parameter int PRESCALE = 144,
    parameter int SLOW_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    output logic tick_fast,
    output logic tick_slow
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int DW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
    localparam logic [DW-1:0] DIV_LAST = DW'(SLOW_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [DW-1:0] div;
    } pst_t;

    pst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            if (st_q.pre == PRE_LAST) begin
                st_d.pre = '0;
                st_d.div = (st_q.div == DIV_LAST) ? '0 : st_q.div + 1'b1;
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_fast = clk_en && (st_q.pre == '0);
    assign tick_slow = tick_fast && (st_q.div == '0);

    // R1
    no_tick_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(st_q));

    generate
        if (PRESCALE > 1) begin : g_gap
            // R1
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_fast |=> !tick_fast);
        end
    endgenerate

endmodule

// File: rtl/dit_counter.sv
module dit_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic [W-1:0] reload,
    output logic         ovf
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cst_t;

    cst_t st_d, st_q;
    logic step;

    always_comb begin
        step = tick && run;
        ovf  = step && (st_q.cnt == '0);
        st_d = st_q;
        if (step) begin
            if (st_q.cnt == '0) st_d.cnt = reload;
            else                st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    reload_on_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (st_q.cnt == $past(reload)));

    // R5
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && run) |=> $stable(st_q.cnt));

endmodule

// File: rtl/dit_busy.sv
module dit_busy #(
    parameter int BUSY_LEN = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic wr,
    output logic busy
);
    localparam int BW = $clog2(BUSY_LEN + 1);
    localparam logic [BW-1:0] LOAD = BW'(BUSY_LEN);

    typedef struct packed {
        logic [BW-1:0] cnt;
    } bst_t;

    bst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr)                               st_d.cnt = LOAD;
        else if (clk_en && st_q.cnt != '0)    st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.cnt != '0);

    // R8
    write_raises_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> busy);

    // R8
    busy_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr));

    // R1
    busy_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !clk_en) |=> $stable(st_q.cnt));

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int PRESCALE = 144,
    parameter int SLOW_DIV = 16,
    parameter int BUSY_LEN = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_en,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] status
);
    localparam int FAST_W = 10;
    localparam int SLOW_W = 8;

    regs_t regs_d, regs_q;
    logic  tick_fast, tick_slow;
    logic  ovf_fast, ovf_slow;
    logic  clr_fast, clr_slow;
    logic  busy;
    logic [FAST_W-1:0] fast_reload;

    dit_prescaler #(.PRESCALE(PRESCALE), .SLOW_DIV(SLOW_DIV)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow)
    );

    assign fast_reload = {regs_q.fast_hi, regs_q.fast_lo};

    dit_counter #(.W(FAST_W)) u_fast (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_fast),
        .run    (regs_q.ctrl.run_fast),
        .reload (fast_reload),
        .ovf    (ovf_fast)
    );

    dit_counter #(.W(SLOW_W)) u_slow (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_slow),
        .run    (regs_q.ctrl.run_slow),
        .reload (regs_q.slow_rel),
        .ovf    (ovf_slow)
    );

    dit_busy #(.BUSY_LEN(BUSY_LEN)) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (clk_en),
        .wr     (wr_en),
        .busy   (busy)
    );

    always_comb begin
        regs_d   = regs_q;
        clr_fast = 1'b0;
        clr_slow = 1'b0;
        if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_FAST_HI: regs_d.fast_hi  = wr_data;
                SEL_FAST_LO: regs_d.fast_lo  = wr_data[1:0];
                SEL_SLOW:    regs_d.slow_rel = wr_data;
                default: begin
                    regs_d.ctrl = ctrl_t'(wr_data[3:0]);
                    clr_fast    = wr_data[CLR_FAST_BIT];
                    clr_slow    = wr_data[CLR_SLOW_BIT];
                end
            endcase
        end
        regs_d.flag_fast = (regs_q.flag_fast && !clr_fast)
                         || (ovf_fast && regs_q.ctrl.ovf_en_fast);
        regs_d.flag_slow = (regs_q.flag_slow && !clr_slow)
                         || (ovf_slow && regs_q.ctrl.ovf_en_slow);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign status = {busy, 5'b0, regs_q.flag_slow, regs_q.flag_fast};

    // R6
    fast_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(ovf_fast && regs_q.ctrl.ovf_en_fast));

    // R6
    slow_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> $past(ovf_slow && regs_q.ctrl.ovf_en_slow));

    // R7
    fast_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !clr_fast) |=> status[0]);

    // R7
    slow_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !clr_slow) |=> status[1]);

endmodule

// File: tb/test_dual_interval_timer.sv
module test_dual_interval_timer;
    localparam int P  = 6;
    localparam int D  = 4;
    localparam int BL = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] status;

    int cyc = 0;
    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dual_interval_timer #(.PRESCALE(P), .SLOW_DIV(D), .BUSY_LEN(BL)) i_dual_interval_timer (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .status(status)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; clk_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_flag(input int b, input int limit, output int t);
        int k = 0;
        while (!status[b] && k < limit) begin
            @(negedge clk);
            k++;
        end
        t = status[b] ? cyc : -1;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (status[7] && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    // R2, R5, R10: fast timer period for reload value r
    task automatic fast_period(input int r);
        int t_en, t0, t1;
        do_reset();
        wr(2'd0, 8'(r >> 2));
        wr(2'd1, 8'hFC | 8'(r & 3));
        wr(2'd3, 8'h05);
        t_en = cyc;
        wait_flag(0, 2 * P + 4, t0);
        chk("R5 first fast overflow within one tick", int'(t0 >= 0 && t0 - t_en <= P), 1);
        wr(2'd3, 8'h15);
        wait_flag(0, (r + 1) * P + 10, t1);
        chk($sformatf("R2 fast period reload %0d", r), t1 - t0, (r + 1) * P);
    endtask

    // R3, R5: slow timer period for reload value r
    task automatic slow_period(input int r);
        int t_en, t0, t1;
        do_reset();
        wr(2'd2, 8'(r));
        wr(2'd3, 8'h0A);
        t_en = cyc;
        wait_flag(1, P * D + 4, t0);
        chk("R5 first slow overflow within one tick", int'(t0 >= 0 && t0 - t_en <= P * D), 1);
        wr(2'd3, 8'h2A);
        wait_flag(1, (r + 1) * P * D + 10, t1);
        chk($sformatf("R3 slow period reload %0d", r), t1 - t0, (r + 1) * P * D);
    endtask

    initial begin
        #1900000;
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int t, n;
        do_reset();
        @(negedge clk);
        chk("R9 status after reset", int'(status), 0);
        repeat (20) @(negedge clk);
        chk("R9 no busy without write", int'(status[7]), 0);

        // R8: busy window length and restart
        wr(2'd0, 8'd0);
        busy_len(n);
        chk("R8 busy length", n, BL);
        wr(2'd1, 8'd0);
        repeat (9) @(negedge clk);
        wr(2'd2, 8'd0);
        busy_len(n);
        chk("R8 busy restart length", n, BL);

        // R1: busy frozen while clk_en low
        @(negedge clk);
        clk_en = 1'b0;
        wr(2'd0, 8'd0);
        repeat (30) @(negedge clk);
        chk("R1 busy held with clk_en low", int'(status[7]), 1);
        clk_en = 1'b1;
        busy_len(n);
        chk("R1 busy resumes count", n, BL);

        // R2 / R3 sweeps
        for (int r = 0; r < 16; r++) fast_period(r);
        fast_period(1023);
        fast_period(341);
        for (int r = 0; r < 8; r++) slow_period(r);
        slow_period(255);

        // R1: timer frozen with clk_en low
        do_reset();
        wr(2'd3, 8'h05);
        wait_flag(0, 2 * P + 4, t);
        wr(2'd3, 8'h15);
        clk_en = 1'b0;
        repeat (50) @(negedge clk);
        chk("R1 no fast overflow with clk_en low", int'(status[0]), 0);
        clk_en = 1'b1;
        wait_flag(0, P + 2, t);
        chk("R1 fast overflow after clk_en back", int'(t >= 0), 1);

        // R4: run bits clear, nothing happens
        do_reset();
        wr(2'd3, 8'h0C);
        repeat (3 * P * D) @(negedge clk);
        chk("R4 stopped timers give no flags", int'(status[1:0]), 0);

        // R6: running without overflow enables
        do_reset();
        wr(2'd3, 8'h03);
        repeat (3 * P * D) @(negedge clk);
        chk("R6 no flags without overflow enable", int'(status[1:0]), 0);
        wr(2'd3, 8'h0F);
        repeat (2 * P * D + 2) @(negedge clk);
        chk("R6 flags with overflow enable", int'(status[1:0]), 3);

        // R7: sticky, selective clear, clear bits not stored
        repeat (2 * P * D) @(negedge clk);
        chk("R7 flags stay set", int'(status[1:0]), 3);
        wr(2'd3, 8'h0C);
        wr(2'd3, 8'h1C);
        chk("R7 clear fast only", int'(status[1:0]), 2);
        wr(2'd3, 8'h2C);
        chk("R7 clear slow", int'(status[1:0]), 0);
        wr(2'd3, 8'h0F);
        repeat (2 * P * D + 2) @(negedge clk);
        chk("R7 clear bits not stored", int'(status[1:0]), 3);
        chk("R10 unused status bits zero", int'(status[6:2]), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule